// File: doc/BRIEF.md
# Fourteen-times oversampled serial receiver with idle-character timeout

This block turns an asynchronous serial line into bytes. It expects frames with one start bit, eight data bits sent least significant bit first, no parity and one stop bit. An internal tick generator samples the line fourteen times per bit period. The tick spacing comes from an 8-bit rate register, so the bit rate is clk / ((rate + 1) × 14). Each finished frame is handed to a downstream buffer as a single-cycle push. The push carries the byte and two tags. One tag marks a stop bit that was sampled low. The other marks a line that stayed low for the whole frame, which is a break.

Sticky status flags record that a framing error or a break has been seen, until they are cleared. A receive-timeout pulse tells the consumer to drain a partly filled buffer. It fires once the downstream buffer has reported data for a chosen number of character times and no new start bit has come in that time.

Top module: `uart14_rx`

## Requirements
- R1: The rate register resets to 0xFF. One tick occurs every (rate + 1) clock cycles, and one bit period lasts 14 ticks.
- R2: A clock cycle with `rate_we_i` high loads `rate_wdata_i` into the rate register. The new value governs the tick spacing from the next tick on.
- R3: `rxd_i` passes through a two-stage synchronizer. A low sample on a tick while idle opens a candidate start bit. If the line is high at tick 7 of that bit, the candidate is dropped and no word is pushed.
- R4: The eight data bits are sampled at tick 7 of each bit period and assembled least significant bit first. At tick 7 of the stop bit, `push_o` pulses for one cycle with the byte on `push_data_o`.
- R5: When the stop bit is sampled low and the byte is non-zero, the word is pushed with `push_ferr_o` = 1 and `push_brk_o` = 0. One cycle after that push, `ferr_flag_o` is set.
- R6: When the start bit, all data bits and the stop bit are all sampled low, the word is pushed as 0x00 with `push_brk_o` = 1 and `push_ferr_o` = 0. One cycle after that push, `brk_flag_o` is set.
- R7: After a break, the receiver ignores the line until it samples it high on a tick. Holding the line low for longer therefore produces no further words.
- R8: Both flags reset to 0. Asserting `sts_clr_i` clears both, but a flag-setting push on the same cycle wins.
- R9: `tmo_sel_i` = 0 disables the timeout. The values 1, 2 and 3 select 4, 8 and 16 character times, where one character time is 140 ticks. When the idle tick count reaches the limit, `timeout_o` pulses for one cycle, and it does not pulse again until the count restarts.
- R10: The idle tick count is held at zero while `fifo_nonempty_i` is low and restarts at every detected start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rate_we_i | input | 1 | Load strobe for the rate register |
| rate_wdata_i | input | RATE_W | New rate divisor value |
| tmo_sel_i | input | 2 | Timeout length select (0 off, 1/2/3 = 4/8/16 characters) |
| fifo_nonempty_i | input | 1 | Downstream buffer holds data |
| sts_clr_i | input | 1 | Clears both sticky flags |
| rxd_i | input | 1 | Serial input line, idle high |
| push_o | output | 1 | One-cycle push of a received word |
| push_data_o | output | DATA_W | Received byte |
| push_ferr_o | output | 1 | Framing-error tag of the pushed word |
| push_brk_o | output | 1 | Break tag of the pushed word |
| ferr_flag_o | output | 1 | Sticky framing-error flag |
| brk_flag_o | output | 1 | Sticky break flag |
| timeout_o | output | 1 | One-cycle receive-timeout pulse |

## Verification
Several rules are checked on every cycle. Pushes and timeout pulses must each last one cycle. A word can never carry both tags, and a break word always holds zero. Ticks can never fall on consecutive cycles unless the rate is zero. The timeout must stay silent while it is disabled or the buffer is empty, and each tagged push must be followed by its flag. Other behaviour only shows up in the bench's scenarios. These cover the exact sampling instant within each bit, false-start rejection of short glitches, and the wait for a high line after a long break. They also cover timeout timing measured from the last start bit, including the restart it causes, and the effect of the reset rate value on actual bit timing.

// File: rtl/uart14_pkg.sv
// Shared constants and types for the oversampled serial receiver.
// Assumes a fixed 8N1 frame; only the divisor and timeout are runtime settings.
package uart14_pkg;
    localparam int OSR         = 14;   // ticks per bit period
    localparam int SAMPLE_TICK = 7;    // tick index used for mid-bit sampling
    localparam int CHAR_BITS   = 10;   // start + 8 data + stop
    localparam int CHAR_TICKS  = OSR * CHAR_BITS;
    localparam int TMO_BASE    = 4;    // character times for the shortest timeout
    localparam int TMO_MAX     = TMO_BASE * 4 * CHAR_TICKS;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_BRKWAIT
    } rx_state_e;
endpackage

// File: rtl/u14_baud.sv
// Rate register and tick divider.
// Emits a one-cycle tick every (rate + 1) clocks; the rate register resets
// to the slowest setting. Assumes writes may arrive at any time.
module u14_baud #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [RATE_W-1:0] wdata_i,
    output logic              tick_o
);
    logic [RATE_W-1:0] rate_q;
    logic [RATE_W-1:0] div_q;

    // Tick when the divider reaches (or, after a rate drop, passes) the rate.
    assign tick_o = (div_q >= rate_q);

    // Holds the divisor written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) rate_q <= '1;
        else if (we_i) rate_q <= wdata_i;
    end

    // Counts clocks between ticks and restarts on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else if (tick_o) div_q <= '0;
        else div_q <= div_q + 1'b1;
    end

    // R1
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (rate_q == '0 || !tick_o));
endmodule

// File: rtl/u14_framer.sv
// Start detection, mid-bit sampling and word assembly for 8N1 frames.
// Samples the synchronized line on each tick; emits a registered push with
// framing and break tags and a combinational start-seen strobe.
module u14_framer
    import uart14_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rxd_i,
    output logic              start_o,
    output logic              push_o,
    output logic [DATA_W-1:0] data_o,
    output logic              ferr_o,
    output logic              brk_o
);
    localparam int TC_W = $clog2(OSR);
    localparam int BC_W = $clog2(DATA_W);
    localparam logic [TC_W-1:0] T_MID  = TC_W'(SAMPLE_TICK);
    localparam logic [TC_W-1:0] T_LAST = TC_W'(OSR - 1);
    localparam logic [BC_W-1:0] B_LAST = BC_W'(DATA_W - 1);

    logic [1:0]        sync_q;
    logic              rx;
    rx_state_e         st_q;
    logic [TC_W-1:0]   tcnt_q;
    logic [BC_W-1:0]   bcnt_q;
    logic [DATA_W-1:0] shreg_q;

    assign rx      = sync_q[1];
    assign start_o = (st_q == RX_IDLE) && tick_i && !rx;

    // Brings the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else sync_q <= {sync_q[0], rxd_i};
    end

    // Frame state machine: one step per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= RX_IDLE;
            tcnt_q  <= '0;
            bcnt_q  <= '0;
            shreg_q <= '0;
            push_o  <= 1'b0;
            data_o  <= '0;
            ferr_o  <= 1'b0;
            brk_o   <= 1'b0;
        end else begin
            push_o <= 1'b0;
            if (tick_i) begin
                case (st_q)
                    RX_IDLE: begin
                        if (!rx) begin
                            st_q   <= RX_START;
                            tcnt_q <= '0;
                        end
                    end
                    RX_START: begin
                        if (tcnt_q == T_MID && rx) begin
                            st_q <= RX_IDLE;
                        end else if (tcnt_q == T_LAST) begin
                            st_q   <= RX_DATA;
                            tcnt_q <= '0;
                            bcnt_q <= '0;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (tcnt_q == T_MID) shreg_q <= {rx, shreg_q[DATA_W-1:1]};
                        if (tcnt_q == T_LAST) begin
                            tcnt_q <= '0;
                            if (bcnt_q == B_LAST) st_q <= RX_STOP;
                            else bcnt_q <= bcnt_q + 1'b1;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (tcnt_q == T_MID) begin
                            push_o <= 1'b1;
                            data_o <= shreg_q;
                            ferr_o <= !rx && (shreg_q != '0);
                            brk_o  <= !rx && (shreg_q == '0);
                            st_q   <= (!rx && shreg_q == '0) ? RX_BRKWAIT : RX_IDLE;
                        end else begin
                            tcnt_q <= tcnt_q + 1'b1;
                        end
                    end
                    RX_BRKWAIT: begin
                        if (rx) st_q <= RX_IDLE;
                    end
                    default: st_q <= RX_IDLE;
                endcase
            end
        end
    end

    // R4
    push_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> !push_o);
    // R6
    tag_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> !(ferr_o && brk_o));
    // R6
    brk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o && brk_o) |-> (data_o == '0));
    // R7
    brkwait_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RX_BRKWAIT) |=> !push_o);
endmodule

// File: rtl/u14_idle_tmo.sv
// Idle-character timeout: counts ticks while the downstream buffer holds
// data and no start bit arrives; pulses once when the selected limit is hit.
module u14_idle_tmo
    import uart14_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       start_i,
    input  logic       nonempty_i,
    input  logic [1:0] sel_i,
    output logic       tmo_o
);
    localparam int TMO_W = $clog2(TMO_MAX + 1);

    logic [TMO_W-1:0] lim;
    logic [TMO_W-1:0] cnt_q;

    // Maps the select code to a tick limit; doubling per step.
    always_comb begin
        case (sel_i)
            2'd1:    lim = TMO_W'(TMO_BASE * CHAR_TICKS);
            2'd2:    lim = TMO_W'(TMO_BASE * 2 * CHAR_TICKS);
            2'd3:    lim = TMO_W'(TMO_BASE * 4 * CHAR_TICKS);
            default: lim = '0;
        endcase
    end

    // Counts idle ticks, saturating at the limit, and emits the pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tmo_o <= 1'b0;
        end else begin
            tmo_o <= 1'b0;
            if (!nonempty_i || sel_i == 2'd0 || start_i) begin
                cnt_q <= '0;
            end else if (tick_i && cnt_q < lim) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q + 1'b1 == lim) tmo_o <= 1'b1;
            end
        end
    end

    // R9
    tmo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i == 2'd0) |=> !tmo_o);
    // R9
    tmo_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_o |=> !tmo_o);
    // R10
    tmo_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nonempty_i |=> !tmo_o);
endmodule

// File: rtl/uart14_rx.sv
// Top of the oversampled receiver: ties the tick divider, the framer and
// the idle timeout together and keeps the sticky error flags.
// Assumes the consumer accepts every push (no backpressure).
module uart14_rx
    import uart14_pkg::*;
#(
    parameter int RATE_W = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rate_we_i,
    input  logic [RATE_W-1:0] rate_wdata_i,
    input  logic [1:0]        tmo_sel_i,
    input  logic              fifo_nonempty_i,
    input  logic              sts_clr_i,
    input  logic              rxd_i,
    output logic              push_o,
    output logic [DATA_W-1:0] push_data_o,
    output logic              push_ferr_o,
    output logic              push_brk_o,
    output logic              ferr_flag_o,
    output logic              brk_flag_o,
    output logic              timeout_o
);
    logic tick;
    logic start_seen;

    u14_baud #(.RATE_W(RATE_W)) baud_i (
        .clk(clk), .rst_n(rst_n), .we_i(rate_we_i), .wdata_i(rate_wdata_i),
        .tick_o(tick)
    );

    u14_framer #(.DATA_W(DATA_W)) framer_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rxd_i(rxd_i),
        .start_o(start_seen), .push_o(push_o), .data_o(push_data_o),
        .ferr_o(push_ferr_o), .brk_o(push_brk_o)
    );

    u14_idle_tmo tmo_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .start_i(start_seen),
        .nonempty_i(fifo_nonempty_i), .sel_i(tmo_sel_i), .tmo_o(timeout_o)
    );

    // Sticky flags: set by a tagged push, cleared by the host; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ferr_flag_o <= 1'b0;
            brk_flag_o  <= 1'b0;
        end else begin
            ferr_flag_o <= (ferr_flag_o && !sts_clr_i) || (push_o && push_ferr_o);
            brk_flag_o  <= (brk_flag_o && !sts_clr_i) || (push_o && push_brk_o);
        end
    end

    // R5
    ferr_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o && push_ferr_o) |=> ferr_flag_o);
    // R6
    brk_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o && push_brk_o) |=> brk_flag_o);
endmodule

// File: tb/uart14_rx_tb.sv
module uart14_rx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rate_we = 1'b0;
    logic [7:0] rate_wd = '0;
    logic [1:0] tmo_sel = '0;
    logic       fifo_ne = 1'b0;
    logic       sts_clr = 1'b0;
    logic       rxd = 1'b1;
    logic       push, pferr, pbrk, fflag, bflag, tmo;
    logic [7:0] pdata;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart14_rx dut_i (
        .clk(clk), .rst_n(rst_n), .rate_we_i(rate_we), .rate_wdata_i(rate_wd),
        .tmo_sel_i(tmo_sel), .fifo_nonempty_i(fifo_ne), .sts_clr_i(sts_clr),
        .rxd_i(rxd), .push_o(push), .push_data_o(pdata), .push_ferr_o(pferr),
        .push_brk_o(pbrk), .ferr_flag_o(fflag), .brk_flag_o(bflag), .timeout_o(tmo)
    );

    int vectors = 0;
    int miss = 0;
    int tmo_seen = 0;
    int push_seen = 0;
    int exp_q[$];
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miss++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miss);
            $finish;
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_rate, m_div, m_s1, m_s2, m_st, m_t, m_bit, m_sh;
    int m_push, m_data, m_ferr, m_brk, m_ff, m_bf, m_tmo, m_cnt;

    always @(posedge clk) begin
        int tk, rxv, lim, stt;
        if (!rst_n) begin
            m_rate = 255; m_div = 0; m_s1 = 1; m_s2 = 1; m_st = 0; m_t = 0;
            m_bit = 0; m_sh = 0; m_push = 0; m_data = 0; m_ferr = 0; m_brk = 0;
            m_ff = 0; m_bf = 0; m_tmo = 0; m_cnt = 0;
        end else begin
            // flags follow the previous cycle's push
            m_ff = ((m_ff != 0 && !sts_clr) || (m_push != 0 && m_ferr != 0)) ? 1 : 0;
            m_bf = ((m_bf != 0 && !sts_clr) || (m_push != 0 && m_brk != 0)) ? 1 : 0;
            tk = (m_div >= m_rate) ? 1 : 0;
            rxv = m_s2;
            stt = 0;
            m_push = 0;
            m_tmo = 0;
            if (tk != 0) begin
                if (m_st == 0) begin
                    if (rxv == 0) begin m_st = 1; m_t = 0; stt = 1; end
                end else if (m_st == 1) begin
                    if (m_t == 7 && rxv == 1) m_st = 0;
                    else if (m_t == 13) begin m_st = 2; m_t = 0; m_bit = 0; end
                    else m_t++;
                end else if (m_st == 2) begin
                    if (m_t == 7) m_sh = (m_sh >> 1) | (rxv << 7);
                    if (m_t == 13) begin
                        m_t = 0;
                        if (m_bit == 7) m_st = 3; else m_bit++;
                    end else m_t++;
                end else if (m_st == 3) begin
                    if (m_t == 7) begin
                        m_push = 1; m_data = m_sh;
                        m_ferr = (rxv == 0 && m_sh != 0) ? 1 : 0;
                        m_brk  = (rxv == 0 && m_sh == 0) ? 1 : 0;
                        m_st = (m_brk != 0) ? 4 : 0;
                    end else m_t++;
                end else begin
                    if (rxv == 1) m_st = 0;
                end
            end
            lim = (tmo_sel == 0) ? 0 : (4 << (tmo_sel - 1)) * 140;
            if (!fifo_ne || tmo_sel == 0 || stt != 0) m_cnt = 0;
            else if (tk != 0 && m_cnt < lim) begin
                m_cnt++;
                if (m_cnt == lim) m_tmo = 1;
            end
            m_s2 = m_s1;
            m_s1 = rxd;
            m_div = (tk != 0) ? 0 : m_div + 1;
            if (rate_we) m_rate = rate_wd;
        end
    end

    // Cycle-by-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(push == m_push[0], "R4 push strobe", push, m_push);
            chk(pdata == m_data[7:0], "R4 push data", pdata, m_data);
            chk(pferr == m_ferr[0], "R5 ferr tag", pferr, m_ferr);
            chk(pbrk == m_brk[0], "R6 break tag", pbrk, m_brk);
            chk(fflag == m_ff[0], "R8 ferr flag", fflag, m_ff);
            chk(bflag == m_bf[0], "R8 break flag", bflag, m_bf);
            chk(tmo == m_tmo[0], "R9 timeout pulse", tmo, m_tmo);
            if (tmo) tmo_seen++;
            if (push) begin
                push_seen++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected push", {pbrk, pferr, pdata}, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk({22'd0, pbrk, pferr, pdata} == e, "R4 word vs stimulus",
                        {pbrk, pferr, pdata}, e);
                end
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_rate(input int r);
        @(negedge clk);
        rate_we = 1'b1; rate_wd = 8'(r);
        @(negedge clk);
        rate_we = 1'b0;
        wait_clk(300);   // let any long pending divider interval end
    endtask

    task automatic send_frame(input logic [7:0] d, input logic stopv, input int bitclk);
        rxd = 1'b0; wait_clk(bitclk);
        for (int b = 0; b < 8; b++) begin rxd = d[b]; wait_clk(bitclk); end
        rxd = stopv;
        wait_clk(stopv ? bitclk : (bitclk * 3) / 4);
        rxd = 1'b1; wait_clk(bitclk);
    endtask

    int base;

    initial begin
        rst_n = 1'b0;
        wait_clk(4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(push == 1'b0 && tmo == 1'b0, "R1 reset outputs idle", {push, tmo}, 0);
        chk(fflag == 1'b0 && bflag == 1'b0, "R8 reset flags clear", {fflag, bflag}, 0);

        // R1: default rate 0xFF gives 256*14 clocks per bit.
        exp_q.push_back(32'h03C);
        send_frame(8'h3C, 1'b1, 256 * 14);
        chk(exp_q.size() == 0, "R1 frame at reset rate", exp_q.size(), 0);

        // R2: rate 1 gives 28 clocks per bit.
        set_rate(1);
        exp_q.push_back(32'h055); send_frame(8'h55, 1'b1, 28);
        exp_q.push_back(32'h000); send_frame(8'h00, 1'b1, 28);
        exp_q.push_back(32'h0FF); send_frame(8'hFF, 1'b1, 28);
        chk(exp_q.size() == 0, "R2 frames after rate write", exp_q.size(), 0);

        // R3: a short low glitch is rejected.
        base = push_seen;
        rxd = 1'b0; wait_clk(6); rxd = 1'b1; wait_clk(400);
        chk(push_seen == base, "R3 glitch rejected", push_seen - base, 0);

        // R5: low stop with non-zero data.
        exp_q.push_back(32'h1A5); send_frame(8'hA5, 1'b0, 28);
        wait_clk(50);
        chk(fflag == 1'b1, "R5 ferr flag set", fflag, 1);
        chk(bflag == 1'b0, "R5 break flag untouched", bflag, 0);

        // R8: clear both flags.
        sts_clr = 1'b1; @(negedge clk); sts_clr = 1'b0; @(negedge clk);
        chk(fflag == 1'b0, "R8 ferr flag cleared", fflag, 0);

        // R6 / R7: long break yields exactly one word.
        base = push_seen;
        exp_q.push_back(32'h200);
        rxd = 1'b0; wait_clk(28 * 20);
        chk(push_seen - base == 1, "R7 one word during long break", push_seen - base, 1);
        chk(bflag == 1'b1, "R6 break flag set", bflag, 1);
        rxd = 1'b1; wait_clk(100);
        exp_q.push_back(32'h081); send_frame(8'h81, 1'b1, 28);
        chk(exp_q.size() == 0, "R7 receive resumes after break", exp_q.size(), 0);

        // R9: timeout of 4 characters at rate 0 (560 clocks).
        set_rate(0);
        fifo_ne = 1'b1; tmo_sel = 2'd1;
        base = tmo_seen;
        exp_q.push_back(32'h012); send_frame(8'h12, 1'b1, 14);
        wait_clk(300);
        chk(tmo_seen == base, "R9 no timeout before 4 chars", tmo_seen - base, 0);
        wait_clk(200);
        chk(tmo_seen == base + 1, "R9 timeout after 4 chars", tmo_seen - base, 1);
        wait_clk(600);
        chk(tmo_seen == base + 1, "R9 single pulse", tmo_seen - base, 1);

        // R10: empty buffer holds the counter.
        fifo_ne = 1'b0;
        base = tmo_seen;
        exp_q.push_back(32'h034); send_frame(8'h34, 1'b1, 14);
        wait_clk(1000);
        chk(tmo_seen == base, "R10 no timeout while empty", tmo_seen - base, 0);

        // R10: start bit restarts the count (8 chars = 1120 clocks).
        fifo_ne = 1'b1; tmo_sel = 2'd2;
        base = tmo_seen;
        exp_q.push_back(32'h056); send_frame(8'h56, 1'b1, 14);
        wait_clk(700);
        exp_q.push_back(32'h078); send_frame(8'h78, 1'b1, 14);
        wait_clk(700);
        chk(tmo_seen == base, "R10 restart by start bit", tmo_seen - base, 0);
        wait_clk(400);
        chk(tmo_seen == base + 1, "R10 timeout after restart", tmo_seen - base, 1);

        // R9: select 0 disables.
        tmo_sel = 2'd0;
        base = tmo_seen;
        exp_q.push_back(32'h09A); send_frame(8'h9A, 1'b1, 14);
        wait_clk(2600);
        chk(tmo_seen == base, "R9 disabled timeout", tmo_seen - base, 0);

        // R9: 16 characters (2240 clocks).
        tmo_sel = 2'd3;
        base = tmo_seen;
        exp_q.push_back(32'h0BC); send_frame(8'hBC, 1'b1, 14);
        wait_clk(1800);
        chk(tmo_seen == base, "R9 no timeout before 16 chars", tmo_seen - base, 0);
        wait_clk(400);
        chk(tmo_seen == base + 1, "R9 timeout after 16 chars", tmo_seen - base, 1);

        chk(exp_q.size() == 0, "R4 all expected words pushed", exp_q.size(), 0);
        finish_run();
    end

    initial begin
        wait_clk(WATCHDOG_CYC);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end
endmodule